// File: doc/BRIEF.md
# Mode-Switched Parallel Port Register Decoder

This block sits between a host register bus and an extended-capability parallel port. Each host access carries a base-relative offset, a read or write strobe, an address-enable qualifier and a byte of data. A 3-bit operating mode, held in the top bits of the extended control register, sets what each offset means. Depending on the mode, the same offset can reach the pin data latch, a configuration register, or a push into a shared transmit FIFO with a particular tag.

The operating mode is the block's state. Its eight states are MODE_SPP (000, plain output), MODE_BIDIR (001, bidirectional), MODE_DFIFO (010, data FIFO), MODE_ECP (011, extended capability), MODE_EPP (100, enhanced), MODE_RSVD (101, reserved), MODE_TEST (110, test FIFO) and MODE_CFG (111, configuration). Reset enters MODE_SPP. There is one kind of transition, LOAD_MODE. An accepted write to the extended control register moves the block from whichever state it is in to the state given by bits 7:5 of the written byte. Any other access leaves the state unchanged.

The block holds the byte latch that drives the eight port pins, the status and control bytes, and configuration byte B. It presents FIFO pushes as a registered byte, a tag bit and a one-cycle valid. Reads return data in the same cycle as the read strobe.

Top module: `pport_regdec`

## Requirements
- R1: After reset, pin_out is 00h, mode_out is 000, the extended control register reads 00h, the status and control registers read 00h, and fifo_push is 0.
- R2: An accepted write to offset 402h is possible in every mode. It sets mode_out to bits 7:5 of the written byte from the next cycle. A read of 402h returns the whole byte written.
- R3: In modes 000 and 001, a write to offset 000h latches the byte, and pin_out shows it unchanged from the next cycle. A read of 000h returns pin_in, not the latch.
- R4: Offsets 001h (status) and 002h (control) are read/write storage in every mode. Bit 5 of the control byte is the direction bit, with 0 meaning forward.
- R5: In mode 011 with direction 0, a write to offset 000h causes a push in the next cycle: fifo_push is 1, fifo_tag is 1 (address/RLE) and fifo_wdata is the byte. Reads of 000h in this mode return 00h.
- R6: With direction 0, a write to offset 400h in mode 010, 011 or 110 causes a push in the next cycle with fifo_tag 0 (data).
- R7: A write to a FIFO offset is dropped, with no push, when direction is 1 or when the mode maps no FIFO to that offset.
- R8: In mode 111, offset 400h reads the fixed configuration byte A (parameter CFGA_VALUE, default 10h), and writes to it change nothing. Offset 401h is read/write configuration byte B. In other modes, 401h reads 00h and writes to it are dropped.
- R9: When aen is 1, writes change no register or pin and cause no push, and reads return 00h.
- R10: Reads of unmapped offset and mode pairs, and all cycles without rd_en, return 00h. Writes to such pairs change nothing that can be seen at the ports.
- R11: Each accepted FIFO write gives exactly one one-cycle fifo_push. Writes in back-to-back cycles give pushes in back-to-back cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_ofs | input | 11 | Base-relative register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| aen | input | 1 | Address-enable qualifier; 1 blocks the access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, same cycle as rd_en |
| pin_in | input | 8 | Sensed state of the port pins |
| pin_out | output | 8 | Latched byte driving the port pins |
| fifo_wdata | output | 8 | Byte pushed into the transmit FIFO |
| fifo_tag | output | 1 | 1 = address/RLE, 0 = data |
| fifo_push | output | 1 | One-cycle push valid |
| mode_out | output | 3 | Current operating mode |

## Verification
The bench uses the default parameters: 11-bit offsets, 8-bit data, direction at control bit 5, and configuration byte A fixed at 10h. These values let the bench reach all three upper offsets, step through all eight mode states, and flip the direction bit. A cycle-level reference model predicts the pins, the mode, every push and every read byte. Back-to-back FIFO writes and qualifier-blocked accesses are included, so ordering and suppression are compared cycle by cycle.

// File: rtl/pport_pkg.sv
package pport_pkg;
    parameter int AW = 11;
    parameter int DW = 8;
    parameter int MW = 3;

    localparam logic [AW-1:0] OFS_DATA = 11'h000;
    localparam logic [AW-1:0] OFS_STAT = 11'h001;
    localparam logic [AW-1:0] OFS_CTRL = 11'h002;
    localparam logic [AW-1:0] OFS_EXT0 = 11'h400;
    localparam logic [AW-1:0] OFS_EXT1 = 11'h401;
    localparam logic [AW-1:0] OFS_ECR  = 11'h402;

    typedef enum logic [MW-1:0] {
        MODE_SPP   = 3'b000,
        MODE_BIDIR = 3'b001,
        MODE_DFIFO = 3'b010,
        MODE_ECP   = 3'b011,
        MODE_EPP   = 3'b100,
        MODE_RSVD  = 3'b101,
        MODE_TEST  = 3'b110,
        MODE_CFG   = 3'b111
    } mode_t;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_AFIFO,
        SEL_DFIFO,
        SEL_STAT,
        SEL_CTRL,
        SEL_CFGA,
        SEL_CFGB,
        SEL_ECR
    } sel_t;
endpackage

// File: rtl/pport_decode.sv
module pport_decode
    import pport_pkg::*;
(
    input  logic [AW-1:0] addr_ofs,
    input  mode_t         mode,
    output sel_t          sel
);
    always_comb begin
        sel = SEL_NONE;
        if (addr_ofs == OFS_STAT) begin
            sel = SEL_STAT;
        end else if (addr_ofs == OFS_CTRL) begin
            sel = SEL_CTRL;
        end else if (addr_ofs == OFS_ECR) begin
            sel = SEL_ECR;
        end else if (addr_ofs == OFS_DATA) begin
            unique case (mode)
                MODE_SPP, MODE_BIDIR: sel = SEL_DATA;
                MODE_ECP:             sel = SEL_AFIFO;
                default:              sel = SEL_NONE;
            endcase
        end else if (addr_ofs == OFS_EXT0) begin
            unique case (mode)
                MODE_DFIFO, MODE_ECP, MODE_TEST: sel = SEL_DFIFO;
                MODE_CFG:                        sel = SEL_CFGA;
                default:                         sel = SEL_NONE;
            endcase
        end else if (addr_ofs == OFS_EXT1 && mode == MODE_CFG) begin
            sel = SEL_CFGB;
        end
    end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int DIR_BIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_acc,
    input  sel_t          sel,
    input  logic [DW-1:0] wdata,
    output mode_t         mode_q,
    output logic [DW-1:0] data_q,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-MW-1:0] ecr_lo_q,
    output logic [DW-1:0] cfgb_q,
    output logic          push_q,
    output logic          push_tag_q,
    output logic [DW-1:0] push_data_q
);
    logic fwd;
    logic push_d;
    logic tag_d;

    assign fwd = ~ctrl_q[DIR_BIT];

    // mode state register: LOAD_MODE on an accepted extended control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_SPP;
            ecr_lo_q <= '0;
        end else if (wr_acc && sel == SEL_ECR) begin
            mode_q   <= mode_t'(wdata[DW-1:DW-MW]);
            ecr_lo_q <= wdata[DW-MW-1:0];
        end
    end

    always_comb begin
        push_d = 1'b0;
        tag_d  = 1'b0;
        if (wr_acc && fwd) begin
            unique case (sel)
                SEL_AFIFO: begin push_d = 1'b1; tag_d = 1'b1; end
                SEL_DFIFO: begin push_d = 1'b1; tag_d = 1'b0; end
                default:   begin push_d = 1'b0; tag_d = 1'b0; end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q      <= '0;
            stat_q      <= '0;
            ctrl_q      <= '0;
            cfgb_q      <= '0;
            push_q      <= 1'b0;
            push_tag_q  <= 1'b0;
            push_data_q <= '0;
        end else begin
            push_q <= push_d;
            if (push_d) begin
                push_tag_q  <= tag_d;
                push_data_q <= wdata;
            end
            if (wr_acc) begin
                unique case (sel)
                    SEL_DATA: data_q <= wdata;
                    SEL_STAT: stat_q <= wdata;
                    SEL_CTRL: ctrl_q <= wdata;
                    SEL_CFGB: cfgb_q <= wdata;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pport_regdec.sv
module pport_regdec
    import pport_pkg::*;
#(
    parameter logic [7:0] CFGA_VALUE = 8'h10,
    parameter int         DIR_BIT    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_ofs,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic          aen,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] fifo_wdata,
    output logic          fifo_tag,
    output logic          fifo_push,
    output logic [MW-1:0] mode_out
);
    mode_t            mode_q;
    sel_t             sel;
    logic [DW-1:0]    data_q, stat_q, ctrl_q, cfgb_q;
    logic [DW-MW-1:0] ecr_lo_q;
    logic             wr_acc;
    logic             rd_acc;

    assign wr_acc = wr_en & ~aen;
    assign rd_acc = rd_en & ~aen;

    pport_decode u_dec (
        .addr_ofs (addr_ofs),
        .mode     (mode_q),
        .sel      (sel)
    );

    pport_regs #(.DIR_BIT(DIR_BIT)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_acc      (wr_acc),
        .sel         (sel),
        .wdata       (host_wdata),
        .mode_q      (mode_q),
        .data_q      (data_q),
        .stat_q      (stat_q),
        .ctrl_q      (ctrl_q),
        .ecr_lo_q    (ecr_lo_q),
        .cfgb_q      (cfgb_q),
        .push_q      (fifo_push),
        .push_tag_q  (fifo_tag),
        .push_data_q (fifo_wdata)
    );

    // output process: read mux and pin drive
    always_comb begin
        host_rdata = '0;
        if (rd_acc) begin
            unique case (sel)
                SEL_DATA: host_rdata = pin_in;
                SEL_STAT: host_rdata = stat_q;
                SEL_CTRL: host_rdata = ctrl_q;
                SEL_ECR:  host_rdata = {mode_q, ecr_lo_q};
                SEL_CFGA: host_rdata = CFGA_VALUE;
                SEL_CFGB: host_rdata = cfgb_q;
                default:  host_rdata = '0;
            endcase
        end
    end

    assign pin_out  = data_q;
    assign mode_out = mode_q;
endmodule

// File: rtl/pport_regdec_chk.sv
module pport_regdec_chk
    import pport_pkg::*;
#(
    parameter logic [7:0] CFGA_VALUE = 8'h10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_ofs,
    input logic          rd_en,
    input logic          wr_en,
    input logic          aen,
    input logic [DW-1:0] host_rdata,
    input logic [DW-1:0] pin_in,
    input logic [DW-1:0] pin_out,
    input logic          fifo_tag,
    input logic          fifo_push,
    input logic [MW-1:0] mode_out
);
    assert_aen_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && aen) |=> ($stable(pin_out) && $stable(mode_out) && !fifo_push));

    assert_aen_blocks_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && aen) |-> (host_rdata == '0));

    assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (host_rdata == '0));

    assert_push_from_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> $past(wr_en && !aen));

    assert_addr_tag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && fifo_tag) |-> $past(mode_out == 3'b011 && addr_ofs == OFS_DATA));

    assert_cfga_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !aen && mode_out == 3'b111 && addr_ofs == OFS_EXT0) |-> (host_rdata == CFGA_VALUE));

    assert_pins_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !aen && mode_out <= 3'b001 && addr_ofs == OFS_DATA) |-> (host_rdata == pin_in));
endmodule

bind pport_regdec pport_regdec_chk #(.CFGA_VALUE(CFGA_VALUE)) u_chk (.*);

// File: tb/tb_pport_regdec.sv
`timescale 1ns/1ps
module tb_pport_regdec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] addr_ofs = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0, aen = 1'b0;
    logic [7:0]  host_wdata = '0, pin_in = 8'h3C;
    logic [7:0]  host_rdata, pin_out, fifo_wdata;
    logic        fifo_tag, fifo_push;
    logic [2:0]  mode_out;

    int checks = 0, failures = 0;
    string cur_req = "R1";
    bit running = 0;

    // behavioural reference state
    int m_mode, m_data, m_stat, m_ctrl, m_ecr, m_cfgb, m_push, m_tag, m_pdata;
    int q_tag[$];
    int q_dat[$];

    always #4 clk = ~clk;

    pport_regdec dut (.*);

    function automatic int exp_read(int ofs, int mode);
        if (ofs == 'h001) return m_stat;
        if (ofs == 'h002) return m_ctrl;
        if (ofs == 'h402) return m_ecr;
        if (ofs == 'h000 && (mode == 0 || mode == 1)) return int'(pin_in);
        if (ofs == 'h400 && mode == 7) return 'h10;
        if (ofs == 'h401 && mode == 7) return m_cfgb;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_data = 0; m_stat = 0; m_ctrl = 0; m_ecr = 0;
            m_cfgb = 0; m_push = 0; m_tag = 0; m_pdata = 0;
        end else begin
            int ofs, d, md;
            bit fwd;
            m_push = 0;
            if (wr_en && !aen) begin
                ofs = int'(addr_ofs); d = int'(host_wdata); md = m_mode;
                fwd = ((m_ctrl >> 5) & 1) == 0;
                if (ofs == 'h001) m_stat = d;
                else if (ofs == 'h002) m_ctrl = d;
                else if (ofs == 'h402) begin m_ecr = d; m_mode = d >> 5; end
                else if (ofs == 'h000 && md <= 1) m_data = d;
                else if (ofs == 'h000 && md == 3 && fwd) begin
                    m_push = 1; q_tag.push_back(1); q_dat.push_back(d);
                end else if (ofs == 'h400 && (md == 2 || md == 3 || md == 6) && fwd) begin
                    m_push = 1; q_tag.push_back(0); q_dat.push_back(d);
                end else if (ofs == 'h401 && md == 7) m_cfgb = d;
            end
            if (m_push) begin m_tag = q_tag.pop_front(); m_pdata = q_dat.pop_front(); end
        end
    end

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            cmp("pin_out", int'(pin_out), m_data);
            cmp("mode_out", int'(mode_out), m_mode);
            cmp("fifo_push", int'(fifo_push), m_push);
            if (m_push) begin
                cmp("fifo_tag", int'(fifo_tag), m_tag);
                cmp("fifo_wdata", int'(fifo_wdata), m_pdata);
            end
            cmp("host_rdata", int'(host_rdata),
                (rd_en && !aen) ? exp_read(int'(addr_ofs), m_mode) : 0);
        end
    end

    task automatic wr(int ofs, int d, bit a, string req);
        @(negedge clk);
        #1 cur_req = req; addr_ofs = 11'(ofs); host_wdata = 8'(d); aen = a; wr_en = 1; rd_en = 0;
    endtask

    task automatic rd(int ofs, bit a, string req);
        @(negedge clk);
        #1 cur_req = req; addr_ofs = 11'(ofs); aen = a; rd_en = 1; wr_en = 0;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            #1 rd_en = 0; wr_en = 0; aen = 0;
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        running = 1;
        cur_req = "R1";
        rd(11'h402, 0, "R1"); rd(11'h001, 0, "R1"); rd(11'h002, 0, "R1"); idle(1);
        // R3 data latch and pin reads
        wr(0, 'hA5, 0, "R3"); rd(0, 0, "R3");
        wr('h402, 'h20, 0, "R2"); wr(0, 'h5A, 0, "R3");
        pin_in = 8'hC1; rd(0, 0, "R3"); idle(1);
        // R4 status/control in several modes
        wr(1, 'h77, 0, "R4"); rd(1, 0, "R4"); wr(2, 'h0F, 0, "R4"); rd(2, 0, "R4");
        wr('h402, 'hE3, 0, "R2"); rd('h402, 0, "R2"); rd(1, 0, "R4"); rd(2, 0, "R4");
        // R5 / R6 pushes
        wr('h402, 'h60, 0, "R2"); wr(0, 'h11, 0, "R5"); rd(0, 0, "R5");
        wr('h400, 'h22, 0, "R6"); idle(1);
        wr('h402, 'h40, 0, "R2"); wr('h400, 'h33, 0, "R6");
        wr('h402, 'hC0, 0, "R2"); wr('h400, 'h44, 0, "R6"); rd('h400, 0, "R10"); idle(1);
        // R7 dropped pushes
        wr(2, 'h20, 0, "R4"); wr('h402, 'h60, 0, "R2");
        wr(0, 'h55, 0, "R7"); wr('h400, 'h66, 0, "R7"); idle(1);
        wr(2, 'h00, 0, "R4"); wr('h402, 'h00, 0, "R2"); wr('h400, 'h77, 0, "R7");
        wr('h402, 'h80, 0, "R2"); wr(0, 'h88, 0, "R7"); wr('h400, 'h89, 0, "R7"); idle(1);
        // R8 configuration mode
        wr('h402, 'hE0, 0, "R2"); rd('h400, 0, "R8"); wr('h400, 'h99, 0, "R8"); rd('h400, 0, "R8");
        wr('h401, 'hC3, 0, "R8"); rd('h401, 0, "R8");
        wr('h402, 'h00, 0, "R2"); rd('h401, 0, "R8"); wr('h401, 'h5C, 0, "R8");
        wr('h402, 'hE0, 0, "R2"); rd('h401, 0, "R8");
        // R9 blocked accesses
        wr('h402, 'h60, 1, "R9"); wr(0, 'h12, 1, "R9"); wr(1, 'hFF, 1, "R9");
        rd(1, 1, "R9"); rd('h402, 1, "R9");
        wr('h402, 'h00, 0, "R2"); wr(0, 'h34, 1, "R9"); rd(0, 1, "R9"); idle(1);
        // R10 unmapped
        rd(3, 0, "R10"); rd('h7FF, 0, "R10"); rd('h403, 0, "R10");
        wr('h402, 'hA0, 0, "R2"); rd(0, 0, "R10"); wr(0, 'hDE, 0, "R10"); rd('h400, 0, "R10");
        wr('h402, 'h80, 0, "R2"); rd(0, 0, "R10"); idle(1);
        // R11 back-to-back pushes
        wr('h402, 'h60, 0, "R2"); wr(0, 'h01, 0, "R11"); wr('h400, 'h02, 0, "R11");
        wr(0, 'h03, 0, "R11"); wr('h400, 'h04, 0, "R11"); idle(3);
        running = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule